// File: doc/BRIEF.md
# Low-Power DRAM Power-Up Sequencer

This block replaces the firmware routine that brings a low-power DDR2 or DDR3 memory device out of power-up. After a synchronous reset it sits idle; a `start` pulse makes it walk a fixed list of device commands, presented on an abstract command port with a valid/ready handshake. Between commands it waits for timed pauses. The pause lengths come from the clock frequency parameter `CLK_FREQ_MHZ` and are rounded up to whole cycles. Alongside the commands it drives the clock-enable line, the impedance calibration mode, a calibration launch strobe and the enable for the data and strobe input pads.

The `lp3_sel` input, sampled on the start cycle, picks between the DDR2 and DDR3 orderings. Both orderings enable the clock, raise CKE, reset the device through mode register 63, calibrate through mode register 10 and program registers 1, 2, 3 and 16. The DDR2 ordering also reads register 0 before calibration. The DDR3 ordering opens the input pads and then reads registers 5, 6, 8 and 0. Both end with the normal-mode command, a final short calibration launch and a done flag. After that the block emits one refresh request every 3.9 us.

Top module: `lpddr_init_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `cmd_valid`, `cke`, `ibuf_en`, `zq_kick`, `done` and `refresh_req` are 0 and `zq_mode` is 0 (off).
- R2: From idle, `start` makes `cmd_valid` rise in the next cycle, and `lp3_sel` is captured at that edge. `start` and `lp3_sel` are ignored while a sequence is running and after it has finished.
- R3: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_type`, `cmd_addr` and `cmd_data` hold. A command is accepted once, on the first cycle with both high. When `cmd_valid` is low, `cmd_type`, `cmd_addr` and `cmd_data` are 0.
- R4: With `lp3_sel`=0, ten commands are issued. The encoding is `cmd_type` 0 NOP, 1 mode register write, 2 mode register read, 3 normal. The order is: NOP, NOP, write 63, read 0, write 10, write 1, write 2, write 3, write 16, normal.
- R5: With `lp3_sel`=1, fourteen commands are issued in this order: NOP, NOP, write 63, write 10, write 1, write 2, write 3, write 16, NOP, read 5, read 6, read 8, read 0, normal.
- R6: After a command is accepted, the next `cmd_valid` rises W+1 cycles after the accepting cycle. W = ceil(pause x f): the pause is 100 ns after the first NOP, 200 us after the second NOP, 10 us after the DDR2 read of register 0, and 1 us after every other command.
- R7: `cke` rises in the cycle after the second NOP is accepted and stays high until reset.
- R8: `zq_mode` is 1 (reset) while the write to register 10 is presented. It is 2 (short) from the cycle after that write is accepted, and 0 before.
- R9: In DDR3 mode, `ibuf_en` rises with `cmd_valid` of the NOP that follows the register 16 write, and falls in the cycle after the normal command is accepted. In DDR2 mode it stays 0.
- R10: When the pause after the normal command ends, `zq_kick` pulses for one cycle with `zq_mode`=2. `done` rises in the following cycle and holds until reset.
- R11: After `done` rises, `refresh_req` pulses for one cycle every REFI = ceil(3.9 us x f) cycles, the first pulse REFI cycles after `done` rises.
- R12: A synchronous reset in the middle of a sequence returns the block to idle, which then waits for a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the power-up sequence from idle |
| lp3_sel | input | 1 | 1 selects the DDR3 ordering, 0 the DDR2 ordering |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Command taken by the controller |
| cmd_type | output | 2 | 0 NOP, 1 register write, 2 register read, 3 normal |
| cmd_addr | output | 6 | Mode register address |
| cmd_data | output | 8 | Mode register write data |
| cke | output | 1 | Device clock enable |
| zq_mode | output | 2 | Calibration mode: 0 off, 1 reset, 2 short |
| zq_kick | output | 1 | One-cycle final calibration launch |
| ibuf_en | output | 1 | Data and strobe input pad enable |
| done | output | 1 | Sequence complete |
| refresh_req | output | 1 | Periodic refresh request pulse |

## Verification
Each result has a fixed delay from the edge that triggers it. `cmd_valid` rises one cycle after `start` and W+1 cycles after an acceptance. `cke`, the switch to short calibration and the pad close appear one cycle after the accepting edge, while the calibration reset mode and the pad open appear together with the presented command. `done` follows `zq_kick` by one cycle, and `refresh_req` comes REFI cycles after `done` and every REFI after that. The bench moves its reference model once per rising edge, using the inputs it set at the preceding falling edge, and compares every output at the next falling edge. Each result is therefore checked in exactly the cycle it is due, while `cmd_ready` stalls at random to stretch the handshake.

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq #(
  parameter int CLK_FREQ_MHZ = 125,
  parameter logic [7:0] MR1_DATA = 8'h43,
  parameter logic [7:0] MR2_DATA = 8'h04,
  parameter logic [7:0] MR3_DATA = 8'h02,
  parameter logic [7:0] MR16_DATA = 8'h00,
  parameter logic [7:0] ZQ_INIT_DATA = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       lp3_sel,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_type,
  output logic [5:0] cmd_addr,
  output logic [7:0] cmd_data,
  output logic       cke,
  output logic [1:0] zq_mode,
  output logic       zq_kick,
  output logic       ibuf_en,
  output logic       done,
  output logic       refresh_req
);

  localparam int W_TOGGLE = (100 * CLK_FREQ_MHZ + 999) / 1000;
  localparam int W_LONG   = 200 * CLK_FREQ_MHZ;
  localparam int W_US     = CLK_FREQ_MHZ;
  localparam int W_RD0    = 10 * CLK_FREQ_MHZ;
  localparam int REFI     = (3900 * CLK_FREQ_MHZ + 999) / 1000;
  localparam int CW       = $clog2(W_LONG + 1);
  localparam int RW       = $clog2(REFI + 1);

  localparam logic [1:0] K_NOP = 2'd0, K_WR = 2'd1, K_RD = 2'd2, K_NORM = 2'd3;
  localparam logic [1:0] ZQ_OFF = 2'd0, ZQ_RESET = 2'd1, ZQ_SHORT = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_KICK, S_DONE} state_t;

  typedef struct packed {
    logic [1:0]    kind;
    logic [5:0]    addr;
    logic [7:0]    data;
    logic [CW-1:0] wait_n;
    logic          cke_on;
    logic          zq_rst;
    logic          buf_open;
    logic          buf_close;
    logic          last;
  } step_t;

  function automatic step_t mk(input logic [1:0] k, input logic [5:0] a,
                               input logic [7:0] d, input int w);
    step_t s;
    s = '0;
    s.kind = k;
    s.addr = a;
    s.data = d;
    s.wait_n = CW'(w);
    return s;
  endfunction

  function automatic step_t lookup(input logic [3:0] i, input logic lp3);
    step_t s;
    s = mk(K_NOP, 6'd0, 8'd0, W_US);
    case (i)
      4'd0: s = mk(K_NOP, 6'd0, 8'd0, W_TOGGLE);
      4'd1: begin s = mk(K_NOP, 6'd0, 8'd0, W_LONG); s.cke_on = 1'b1; end
      4'd2: s = mk(K_WR, 6'd63, 8'd0, W_US);
      default: begin
        if (!lp3) begin
          case (i)
            4'd3: s = mk(K_RD, 6'd0, 8'd0, W_RD0);
            4'd4: begin s = mk(K_WR, 6'd10, ZQ_INIT_DATA, W_US); s.zq_rst = 1'b1; end
            4'd5: s = mk(K_WR, 6'd1, MR1_DATA, W_US);
            4'd6: s = mk(K_WR, 6'd2, MR2_DATA, W_US);
            4'd7: s = mk(K_WR, 6'd3, MR3_DATA, W_US);
            4'd8: s = mk(K_WR, 6'd16, MR16_DATA, W_US);
            default: begin s = mk(K_NORM, 6'd0, 8'd0, W_US); s.last = 1'b1; end
          endcase
        end else begin
          case (i)
            4'd3:  begin s = mk(K_WR, 6'd10, ZQ_INIT_DATA, W_US); s.zq_rst = 1'b1; end
            4'd4:  s = mk(K_WR, 6'd1, MR1_DATA, W_US);
            4'd5:  s = mk(K_WR, 6'd2, MR2_DATA, W_US);
            4'd6:  s = mk(K_WR, 6'd3, MR3_DATA, W_US);
            4'd7:  s = mk(K_WR, 6'd16, MR16_DATA, W_US);
            4'd8:  begin s = mk(K_NOP, 6'd0, 8'd0, W_US); s.buf_open = 1'b1; end
            4'd9:  s = mk(K_RD, 6'd5, 8'd0, W_US);
            4'd10: s = mk(K_RD, 6'd6, 8'd0, W_US);
            4'd11: s = mk(K_RD, 6'd8, 8'd0, W_US);
            4'd12: s = mk(K_RD, 6'd0, 8'd0, W_US);
            default: begin
              s = mk(K_NORM, 6'd0, 8'd0, W_US);
              s.buf_close = 1'b1;
              s.last = 1'b1;
            end
          endcase
        end
      end
    endcase
    return s;
  endfunction

  state_t        st;
  logic [3:0]    idx;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rcnt;
  logic          lp3_q, cke_q, ibuf_q, ref_q;
  logic [1:0]    zq_q;
  step_t         cur;

  assign cur       = lookup(idx, lp3_q);
  assign cmd_valid = (st == S_ISSUE);
  assign cmd_type  = cmd_valid ? cur.kind : K_NOP;
  assign cmd_addr  = cmd_valid ? cur.addr : 6'd0;
  assign cmd_data  = cmd_valid ? cur.data : 8'd0;
  assign cke       = cke_q;
  assign zq_mode   = (cmd_valid && cur.zq_rst) ? ZQ_RESET : zq_q;
  assign ibuf_en   = ibuf_q | (cmd_valid & cur.buf_open);
  assign zq_kick   = (st == S_KICK);
  assign done      = (st == S_DONE);
  assign refresh_req = ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      idx    <= '0;
      cnt    <= '0;
      rcnt   <= '0;
      lp3_q  <= 1'b0;
      cke_q  <= 1'b0;
      ibuf_q <= 1'b0;
      ref_q  <= 1'b0;
      zq_q   <= ZQ_OFF;
    end else begin
      ref_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          lp3_q <= lp3_sel;
          idx   <= '0;
          st    <= S_ISSUE;
        end
        S_ISSUE: if (cmd_ready) begin
          cnt <= cur.wait_n - CW'(1);
          st  <= S_WAIT;
          if (cur.cke_on)    cke_q  <= 1'b1;
          if (cur.zq_rst)    zq_q   <= ZQ_SHORT;
          if (cur.buf_open)  ibuf_q <= 1'b1;
          if (cur.buf_close) ibuf_q <= 1'b0;
        end
        S_WAIT: begin
          if (cnt == '0) begin
            if (cur.last) st <= S_KICK;
            else begin
              idx <= idx + 4'd1;
              st  <= S_ISSUE;
            end
          end else cnt <= cnt - CW'(1);
        end
        S_KICK: begin
          st   <= S_DONE;
          rcnt <= RW'(REFI - 1);
        end
        default: begin
          if (rcnt == '0) begin
            ref_q <= 1'b1;
            rcnt  <= RW'(REFI - 1);
          end else rcnt <= rcnt - RW'(1);
        end
      endcase
    end
  end

endmodule

// File: rtl/lpddr_init_seq_chk.sv
module lpddr_init_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_type,
  input logic [5:0] cmd_addr,
  input logic [7:0] cmd_data,
  input logic       cke,
  input logic [1:0] zq_mode,
  input logic       zq_kick,
  input logic       ibuf_en,
  input logic       done,
  input logic       refresh_req
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!cmd_valid && !cke && !ibuf_en && !zq_kick && !done && !refresh_req && zq_mode == 2'd0));

  assert_hold_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_type) && $stable(cmd_addr) && $stable(cmd_data)));

  assert_cke_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  assert_zq_reset_on_mr10_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_type == 2'd1 && cmd_addr == 6'd10) |-> zq_mode == 2'd1);

  assert_ibuf_needs_cke_R9: assert property (@(posedge clk) disable iff (rst)
    ibuf_en |-> cke);

  assert_kick_short_R10: assert property (@(posedge clk) disable iff (rst)
    zq_kick |-> (zq_mode == 2'd2 && !cmd_valid));

  assert_kick_then_done_R10: assert property (@(posedge clk) disable iff (rst)
    zq_kick |=> done);

  assert_done_holds_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !cmd_valid));

  assert_refresh_after_done_R11: assert property (@(posedge clk) disable iff (rst)
    refresh_req |-> done);

  assert_one_refresh_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    refresh_req |=> !refresh_req);

endmodule

bind lpddr_init_seq lpddr_init_seq_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_type(cmd_type), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cke(cke),
  .zq_mode(zq_mode), .zq_kick(zq_kick), .ibuf_en(ibuf_en), .done(done),
  .refresh_req(refresh_req)
);

// File: tb/tb_lpddr_init_seq.sv
module tb_lpddr_init_seq;
  localparam int F    = 125;
  localparam int REFI = 488;

  logic clk = 1'b0;
  logic rst, start, lp3_sel, cmd_ready;
  logic cmd_valid, cke, zq_kick, ibuf_en, done, refresh_req;
  logic [1:0] cmd_type, zq_mode;
  logic [5:0] cmd_addr;
  logic [7:0] cmd_data;

  always #4 clk = ~clk;

  lpddr_init_seq dut (
    .clk(clk), .rst(rst), .start(start), .lp3_sel(lp3_sel),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_type(cmd_type),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cke(cke), .zq_mode(zq_mode),
    .zq_kick(zq_kick), .ibuf_en(ibuf_en), .done(done), .refresh_req(refresh_req)
  );

  int total = 0, bad = 0;
  int q_kind[$], q_addr[$], q_data[$], q_wait[$], q_flag[$];
  int ms = 0, mi = 0, mcnt = 0, mrc = 0, mzq = 0;
  bit mcke = 0, mibuf = 0, mref = 0;
  bit stall = 0;
  logic [7:0] lfsr = 8'hA5;
  int accepted = 0, pulses = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic add(input int k, input int a, input int d, input int w, input int fl);
    q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d);
    q_wait.push_back(w); q_flag.push_back(fl);
  endtask

  // flags: 1 cke on accept, 2 zq reset while shown, 4 pads open, 8 pads close
  task automatic build(input bit lp3);
    q_kind.delete(); q_addr.delete(); q_data.delete(); q_wait.delete(); q_flag.delete();
    add(0, 0, 0, 13, 0);
    add(0, 0, 0, 200 * F, 1);
    add(1, 63, 0, F, 0);
    if (!lp3) begin
      add(2, 0, 0, 10 * F, 0);
      add(1, 10, 8'hFF, F, 2);
      add(1, 1, 8'h43, F, 0); add(1, 2, 8'h04, F, 0);
      add(1, 3, 8'h02, F, 0); add(1, 16, 8'h00, F, 0);
      add(3, 0, 0, F, 0);
    end else begin
      add(1, 10, 8'hFF, F, 2);
      add(1, 1, 8'h43, F, 0); add(1, 2, 8'h04, F, 0);
      add(1, 3, 8'h02, F, 0); add(1, 16, 8'h00, F, 0);
      add(0, 0, 0, F, 4);
      add(2, 5, 0, F, 0); add(2, 6, 0, F, 0); add(2, 8, 0, F, 0); add(2, 0, 0, F, 0);
      add(3, 0, 0, F, 8);
    end
  endtask

  task automatic model_edge();
    mref = 0;
    if (rst) begin
      ms = 0; mi = 0; mcke = 0; mibuf = 0; mzq = 0;
      return;
    end
    case (ms)
      0: if (start) begin build(lp3_sel); mi = 0; ms = 1; end
      1: if (cmd_ready) begin
        mcnt = q_wait[mi]; ms = 2;
        if (q_flag[mi] & 1) mcke = 1;
        if (q_flag[mi] & 2) mzq = 2;
        if (q_flag[mi] & 4) mibuf = 1;
        if (q_flag[mi] & 8) mibuf = 0;
      end
      2: begin
        mcnt--;
        if (mcnt == 0) begin
          if (mi == q_kind.size() - 1) ms = 3;
          else begin mi++; ms = 1; end
        end
      end
      3: begin ms = 4; mrc = 0; end
      default: begin mrc++; if (mrc % REFI == 0) mref = 1; end
    endcase
  endtask

  task automatic compare();
    bit v;
    v = (ms == 1);
    chk("R6 cmd_valid timing", cmd_valid, v);
    chk("R3/R4/R5 cmd_type", cmd_type, v ? q_kind[mi] : 0);
    chk("R3/R4/R5 cmd_addr", cmd_addr, v ? q_addr[mi] : 0);
    chk("R3/R4/R5 cmd_data", cmd_data, v ? q_data[mi] : 0);
    chk("R7 cke", cke, mcke);
    chk("R8 zq_mode", zq_mode, (v && (q_flag[mi] & 2) != 0) ? 1 : mzq);
    chk("R9 ibuf_en", ibuf_en, mibuf | (v && (q_flag[mi] & 4) != 0));
    chk("R10 zq_kick", zq_kick, ms == 3);
    chk("R10 done", done, ms == 4);
    chk("R11 refresh_req", refresh_req, mref);
  endtask

  task automatic tick();
    if (stall) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cmd_ready = lfsr[0] | lfsr[1];
    end else cmd_ready = 1'b1;
    if (cmd_valid && cmd_ready && !rst) accepted++;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    if (refresh_req) pulses++;
    compare();
  endtask

  task automatic run_to_done();
    for (int g = 0; g < 40000 && ms != 4; g++) tick();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; start = 0; lp3_sel = 0; cmd_ready = 0;
    @(negedge clk);
    repeat (3) tick();
    chk("R1 valid in reset", cmd_valid, 0);
    chk("R1 cke in reset", cke, 0);
    chk("R1 ibuf in reset", ibuf_en, 0);
    chk("R1 zq in reset", zq_mode, 0);
    rst = 0;
    repeat (2) tick();
    chk("R1 idle without start", cmd_valid, 0);

    // DDR2 ordering with ready stalls; mid-run start and select changes ignored
    stall = 1; lp3_sel = 0; start = 1; accepted = 0;
    tick();
    start = 0;
    chk("R2 valid one cycle after start", cmd_valid, 1);
    lp3_sel = 1;
    repeat (40) tick();
    start = 1; tick(); start = 0;
    chk("R2 start ignored while busy", done, 0);
    run_to_done();
    chk("R4 commands accepted in DDR2 order", accepted, 10);
    chk("R9 pads stay closed in DDR2", ibuf_en, 0);
    pulses = 0;
    repeat (3 * REFI) tick();
    chk("R11 refresh pulses in three periods", pulses, 3);
    start = 1; tick(); start = 0;
    chk("R2 start ignored after done", cmd_valid, 0);
    chk("R2 done held after start", done, 1);

    // reset in the long pause
    rst = 1; tick(); rst = 0;
    lp3_sel = 1; start = 1; tick(); start = 0;
    repeat (200) tick();
    chk("R7 cke high during long pause", cke, 1);
    rst = 1; tick(); rst = 0;
    chk("R12 cke cleared by reset", cke, 0);
    chk("R12 valid cleared by reset", cmd_valid, 0);
    repeat (5) tick();
    chk("R12 stays idle", cmd_valid, 0);

    // DDR3 ordering, ready always high
    stall = 0; lp3_sel = 1; start = 1; accepted = 0;
    tick();
    start = 0; lp3_sel = 0;
    run_to_done();
    chk("R5 commands accepted in DDR3 order", accepted, 14);
    chk("R9 pads closed at done", ibuf_en, 0);
    chk("R8 zq short at done", zq_mode, 2);
    repeat (REFI + 2) tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule